// File: doc/BRIEF.md
# PS/2 Keyboard Scan Code Receiver

This block takes the two open-collector lines of a PS/2 keyboard, a clock and a data line, and turns each serial frame into an 8-bit scan code. Both lines are oversampled by the fast system clock. The keyboard clock is passed through a synchroniser and a persistence filter. Each falling edge of the filtered clock captures one data bit. A frame is 11 bits: a start bit of 0, eight data bits with the least significant bit first, an odd parity bit and a stop bit of 1.

A good frame loads the code into an output register and raises a ready flag. The flag stays high until the consumer pulses a read strobe, so each code is taken exactly once. Frames that fail their checks are dropped. Every byte is reported as its own event, including prefix bytes. A key release therefore shows as 0xF0 followed by the key code, and a held key shows as a run of separate events. If the keyboard clock stops in the middle of a frame, a watchdog returns the receiver to waiting for a start bit.

Top module: `kbd_scan_rx`

## Requirements
- R1: After a good frame, `code_out` holds the eight data bits. The first data bit received goes to bit 0 and the last to bit 7.
- R2: `code_valid` rises one cycle after a frame is accepted. `code_valid` never rises without an accepted frame. `code_out` changes only when a frame is accepted.
- R3: A one-cycle pulse on `rd_strobe` clears `code_valid` on the next clock edge and leaves `code_out` unchanged. If a frame is accepted in the same cycle as the strobe, the frame wins and `code_valid` stays high.
- R4: A release sequence (0xF0 then the key code) is delivered as two separate ready events, in the order received.
- R5: Repeated identical codes, as sent while a key is held, each raise a new ready event after the previous one was read.
- R6: A frame is discarded when its parity is even. Parity is counted over the 8 data bits plus the parity bit. A discarded frame leaves `code_valid` and `code_out` unchanged.
- R7: A frame whose stop bit is 0 is discarded. It leaves `code_valid` and `code_out` unchanged.
- R8: If no filtered keyboard-clock falling edge arrives for `TIMEOUT_CYC` system cycles inside a frame, the bit position returns to idle. A following complete frame then decodes correctly.
- R9: A level on the keyboard clock line that lasts fewer than `FILT_LEN` system cycles is ignored.
- R10: Synchronous active-low reset clears `code_valid`, `code_out` (to 0x00) and any partly received frame.
- R11: A frame accepted while `code_valid` is still high replaces `code_out` with the newer code. `code_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the keyboard lines |
| rst_n | input | 1 | Synchronous active-low reset |
| line_clk | input | 1 | Keyboard clock line, asynchronous |
| line_dat | input | 1 | Keyboard data line, asynchronous |
| rd_strobe | input | 1 | Consumer read pulse; clears the ready flag |
| code_out | output | 8 | Last accepted scan code |
| code_valid | output | 1 | Sticky flag: a code is waiting to be read |

## Verification
If the bit position is wrong after a stray edge, a timeout or a reset, the next good frame comes out with its bits rotated or is dropped at the parity check. That shows at `code_out` or `code_valid` within one frame time. A fault in the hold register shows up directly. A lost read shows as `code_valid` still high in the cycle after the strobe. A lost frame shows as no ready event a few tens of cycles after the stop bit. The reference model in the bench compares both outputs on every settled clock cycle, so a fault of this kind is caught within one frame.

// File: rtl/kbd_rx_pkg.sv
// Shared constants and helpers for the keyboard scan code receiver.
// Assumes an 11-bit frame: start, 8 data bits LSB first, odd parity, stop.
package kbd_rx_pkg;
    localparam int FRAME_BITS = 11;
    localparam int CODE_W     = 8;
    localparam int POS_W      = $clog2(FRAME_BITS);

    typedef logic [CODE_W-1:0] code_t;

    // True when data bits plus the parity bit hold an odd count of ones.
    function automatic logic parity_odd(input code_t d, input logic p);
        return ^{d, p};
    endfunction
endpackage

// File: rtl/kbd_line_filter.sv
// Synchronises both keyboard lines into the system clock domain and
// applies a persistence filter to the clock line. A new clock level is
// accepted only after it has been stable for FILT_LEN cycles. Emits a
// one-cycle pulse on each accepted falling edge.
// Assumes: line_clk idles high; line_dat is stable around clock edges.
module kbd_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_clk,
    input  logic line_dat,
    output logic clk_fall,
    output logic dat_sync
);
    localparam int FW = $clog2(FILT_LEN + 1);

    logic [1:0] raw_in;
    logic [1:0] synced;
    logic       flt_lvl;
    logic [FW-1:0] flt_cnt;

    assign raw_in = {line_dat, line_clk};

    // One synchroniser chain per line, idle level high.
    for (genvar gi = 0; gi < 2; gi++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        // Shift the raw line through the synchroniser flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], raw_in[gi]};
        end
        assign synced[gi] = chain[SYNC_STAGES-1];
    end

    // Accept a new clock level once it has persisted FILT_LEN cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_lvl  <= 1'b1;
            flt_cnt  <= '0;
            clk_fall <= 1'b0;
        end else begin
            clk_fall <= 1'b0;
            if (synced[0] == flt_lvl) begin
                flt_cnt <= '0;
            end else if (flt_cnt == FW'(FILT_LEN - 1)) begin
                flt_lvl  <= synced[0];
                flt_cnt  <= '0;
                clk_fall <= flt_lvl;
            end else begin
                flt_cnt <= flt_cnt + 1'b1;
            end
        end
    end

    assign dat_sync = synced[1];
endmodule

// File: rtl/kbd_frame_shift.sv
// Assembles one frame from data bits sampled at filtered clock falls.
// Checks the stop bit and odd parity, and flags a good byte for one cycle.
// A watchdog returns the bit position to idle when the clock stalls
// mid-frame for TIMEOUT_CYC cycles.
module kbd_frame_shift
    import kbd_rx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 4800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_fall,
    input  logic             dat_sync,
    output logic             frm_ok,
    output code_t            frm_byte,
    output logic [POS_W-1:0] bit_pos
);
    localparam int IW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [POS_W-1:0] POS_PAR  = POS_W'(FRAME_BITS - 2);
    localparam logic [POS_W-1:0] POS_STOP = POS_W'(FRAME_BITS - 1);

    code_t         shreg;
    logic          par_bit;
    logic [IW-1:0] idle_cnt;

    // Step through start, data, parity and stop positions on each fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_pos  <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            frm_ok   <= 1'b0;
            frm_byte <= '0;
        end else begin
            frm_ok <= 1'b0;
            if (clk_fall) begin
                if (bit_pos == '0) begin
                    if (!dat_sync) bit_pos <= 1;
                end else if (bit_pos < POS_PAR) begin
                    shreg   <= {dat_sync, shreg[CODE_W-1:1]};
                    bit_pos <= bit_pos + 1'b1;
                end else if (bit_pos == POS_PAR) begin
                    par_bit <= dat_sync;
                    bit_pos <= POS_STOP;
                end else begin
                    bit_pos <= '0;
                    if (dat_sync && parity_odd(shreg, par_bit)) begin
                        frm_ok   <= 1'b1;
                        frm_byte <= shreg;
                    end
                end
            end else if (bit_pos != '0 && idle_cnt == IW'(TIMEOUT_CYC - 1)) begin
                bit_pos <= '0;
            end
        end
    end

    // Count cycles since the last fall while a frame is open.
    always_ff @(posedge clk) begin
        if (!rst_n || clk_fall || bit_pos == '0) idle_cnt <= '0;
        else if (idle_cnt == IW'(TIMEOUT_CYC - 1)) idle_cnt <= '0;
        else idle_cnt <= idle_cnt + 1'b1;
    end
endmodule

// File: rtl/kbd_code_hold.sv
// Output register and sticky ready flag. A good frame loads the code and
// sets the flag. The read strobe clears the flag; a frame accepted in the
// same cycle takes precedence over the strobe.
module kbd_code_hold
    import kbd_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  frm_ok,
    input  code_t frm_byte,
    input  logic  rd_strobe,
    output code_t code_out,
    output logic  code_valid
);
    // Load on a good frame, clear the flag on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out   <= '0;
            code_valid <= 1'b0;
        end else if (frm_ok) begin
            code_out   <= frm_byte;
            code_valid <= 1'b1;
        end else if (rd_strobe) begin
            code_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/kbd_scan_rx.sv
// Top level of the PS/2 keyboard scan code receiver: line filter, frame
// assembler and code hold register. Assumes the system clock is at least
// several times faster than FILT_LEN times the keyboard clock rate.
module kbd_scan_rx #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int TIMEOUT_CYC = 4800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_clk,
    input  logic       line_dat,
    input  logic       rd_strobe,
    output logic [7:0] code_out,
    output logic       code_valid
);
    import kbd_rx_pkg::*;

    logic             clk_fall;
    logic             dat_sync;
    logic             frm_ok;
    code_t            frm_byte;
    logic [POS_W-1:0] bit_pos;

    kbd_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .line_dat(line_dat),
        .clk_fall(clk_fall), .dat_sync(dat_sync)
    );

    kbd_frame_shift #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
        .clk(clk), .rst_n(rst_n), .clk_fall(clk_fall), .dat_sync(dat_sync),
        .frm_ok(frm_ok), .frm_byte(frm_byte), .bit_pos(bit_pos)
    );

    kbd_code_hold u_hold (
        .clk(clk), .rst_n(rst_n), .frm_ok(frm_ok), .frm_byte(frm_byte),
        .rd_strobe(rd_strobe), .code_out(code_out), .code_valid(code_valid)
    );
endmodule

// File: rtl/kbd_scan_rx_chk.sv
// Assertion checker for kbd_scan_rx, attached with bind below.
module kbd_scan_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_strobe,
    input logic [7:0] code_out,
    input logic       code_valid,
    input logic       frm_ok,
    input logic [7:0] frm_byte,
    input logic       clk_fall,
    input logic [3:0] bit_pos
);
    // R2
    load_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ok |=> (code_valid && code_out == $past(frm_byte)));
    // R2
    valid_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_valid) |-> $past(frm_ok));
    // R2
    code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_ok |=> $stable(code_out));
    // R3
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !frm_ok) |=> !code_valid);
    // R3
    frame_beats_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && frm_ok) |=> code_valid);
    // R8
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_pos <= 4'd10);
    // R9
    fall_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_fall |=> !clk_fall);
    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!code_valid && code_out == 8'h00 && bit_pos == 4'd0));
endmodule

bind kbd_scan_rx kbd_scan_rx_chk chk_i (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .code_out(code_out),
    .code_valid(code_valid), .frm_ok(frm_ok), .frm_byte(frm_byte),
    .clk_fall(clk_fall), .bit_pos(bit_pos)
);

// File: tb/kbd_scan_rx_tb_top.sv
// Bench for kbd_scan_rx: drives serial frames and keeps a behavioural
// model of the expected ready flag and code, compared on settled cycles.
module kbd_scan_rx_tb_top;
    localparam int HALF = 20;   // system cycles per keyboard clock phase

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_clk = 1'b1;
    logic       line_dat = 1'b1;
    logic       rd_strobe = 1'b0;
    logic [7:0] code_out;
    logic       code_valid;

    int  checks = 0;
    int  failures = 0;
    bit  settled = 1'b0;
    bit  exp_valid = 1'b0;
    logic [7:0] exp_code = 8'h00;
    int  cyc = 0;

    always #4 clk = ~clk;

    kbd_scan_rx dut_i (
        .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .line_dat(line_dat),
        .rd_strobe(rd_strobe), .code_out(code_out), .code_valid(code_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model on settled cycles (R2 R3).
    always @(posedge clk) begin
        cyc++;
        #2;
        if (settled && rst_n) begin
            check("R2/R3 valid", int'(code_valid), int'(exp_valid));
            check("R1/R2 code", int'(code_out), int'(exp_code));
        end
    end

    // Drive one keyboard clock cycle carrying bit b.
    task automatic put_bit(input logic b);
        @(negedge clk) line_dat = b;
        repeat (HALF) @(negedge clk);
        line_clk = 1'b0;
        repeat (HALF) @(negedge clk);
        line_clk = 1'b1;
    endtask

    // Send a full frame and update the model when it is good.
    task automatic send(input logic [7:0] b, input bit bad_par, input bit bad_stop);
        settled = 1'b0;
        put_bit(1'b0);
        for (int i = 0; i < 8; i++) put_bit(b[i]);
        put_bit((~^b) ^ bad_par);
        put_bit(~bad_stop);
        @(negedge clk) line_dat = 1'b1;
        repeat (30) @(negedge clk);
        if (!bad_par && !bad_stop) begin
            exp_valid = 1'b1;
            exp_code  = b;
        end
        settled = 1'b1;
    endtask

    // Pulse the read strobe for one cycle.
    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(posedge clk) #1 exp_valid = 1'b0;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R10: reset state
        check("R10 reset valid", int'(code_valid), 0);
        check("R10 reset code", int'(code_out), 0);
        rst_n = 1'b1;
        settled = 1'b1;
        repeat (5) @(negedge clk);

        // R1 R2: basic decode with several bit patterns
        send(8'h1C, 0, 0);
        check("R1 code 1C", int'(code_out), 'h1C);
        check("R2 valid after frame", int'(code_valid), 1);
        // R3: read clears the flag, code retained
        do_read();
        @(negedge clk);
        check("R3 valid cleared", int'(code_valid), 0);
        check("R3 code kept", int'(code_out), 'h1C);
        send(8'hA5, 0, 0); check("R1 code A5", int'(code_out), 'hA5); do_read();
        send(8'h00, 0, 0); check("R1 code 00", int'(code_out), 'h00); do_read();
        send(8'hFF, 0, 0); check("R1 code FF", int'(code_out), 'hFF); do_read();
        send(8'h01, 0, 0); check("R1 code 01 lsb first", int'(code_out), 'h01); do_read();

        // R4: release sequence as two events
        send(8'hF0, 0, 0); check("R4 prefix F0", int'(code_out), 'hF0);
        check("R4 prefix ready", int'(code_valid), 1); do_read();
        send(8'h1C, 0, 0); check("R4 key after prefix", int'(code_out), 'h1C);
        check("R4 second ready", int'(code_valid), 1); do_read();

        // R5: repeated make codes each raise ready
        for (int k = 0; k < 3; k++) begin
            send(8'h12, 0, 0);
            check("R5 repeat ready", int'(code_valid), 1);
            check("R5 repeat code", int'(code_out), 'h12);
            do_read();
        end

        // R6: bad parity discarded
        send(8'h33, 1, 0);
        check("R6 bad parity no ready", int'(code_valid), 0);
        check("R6 bad parity code kept", int'(code_out), 'h12);
        // R7: bad stop discarded
        send(8'h44, 0, 1);
        check("R7 bad stop no ready", int'(code_valid), 0);
        check("R7 bad stop code kept", int'(code_out), 'h12);

        // R8: stalled partial frame, then a good frame
        settled = 1'b0;
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        repeat (5200) @(negedge clk);
        settled = 1'b1;
        send(8'h5A, 0, 0);
        check("R8 decode after timeout", int'(code_out), 'h5A);
        do_read();

        // R9: short clock glitch with data low is ignored
        settled = 1'b0;
        @(negedge clk) line_dat = 1'b0;
        repeat (5) @(negedge clk);
        line_clk = 1'b0;
        repeat (2) @(negedge clk);
        line_clk = 1'b1;
        repeat (10) @(negedge clk);
        line_dat = 1'b1;
        repeat (10) @(negedge clk);
        settled = 1'b1;
        check("R9 glitch no ready", int'(code_valid), 0);
        send(8'h6B, 0, 0);
        check("R9 decode after glitch", int'(code_out), 'h6B);
        do_read();

        // R11: newer frame overwrites an unread code
        send(8'h11, 0, 0);
        send(8'h22, 0, 0);
        check("R11 newest code", int'(code_out), 'h22);
        check("R11 still ready", int'(code_valid), 1);

        // R10: reset mid-frame clears flag and partial frame
        settled = 1'b0;
        put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_valid = 1'b0; exp_code = 8'h00;
        @(negedge clk);
        check("R10 reset clears valid", int'(code_valid), 0);
        check("R10 reset clears code", int'(code_out), 0);
        settled = 1'b1;
        send(8'h77, 0, 0);
        check("R10 decode after reset", int'(code_out), 'h77);
        do_read();

        repeat (10) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule